// File: doc/BRIEF.md
# Vector Element Rearrangement Unit

This block rearranges the elements of two 128-bit source vectors, A and B. The element width is chosen per request by a size code: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. One operation code picks one of five shapes:

- interleave the upper or lower halves of A and B;
- narrow A and B into one vector;
- widen half of A with sign or zero extension;
- sign-extend two chosen elements of A to 64 bits each.

A request is presented with a one-cycle valid strobe. The result and an error flag are registered and appear one cycle later with their own valid strobe. Both are computed from the operands sampled on the strobe edge, so a caller may write the result back over either source. A size code that the chosen operation does not support sets the error flag and forces the result to zero.

Element numbering starts at the most significant end. Element i of width W occupies bits [127 - i*W -: W] of a vector.

Top module: `vec_shuffle_unit`

## Requirements
- R1: With op code 0 (interleave-upper), destination element d equals element d/2 (integer division) of A when d is even, and of B when d is odd, at the requested width.
- R2: With op code 1 (interleave-lower), destination element d equals element (d+N)/2 of A when d is even, and of B when d is odd. N is the element count, 128/W.
- R3: Op codes 0 and 1 accept size codes 0 to 3 and set no error. Size codes 4 to 7 set the error flag.
- R4: With op code 2 (narrow), the source width is S and the destination width is S/2. For d < N (N = 128/S), destination element d is the low S/2 bits of A element d. For d ≥ N it is the low S/2 bits of B element d-N.
- R5: Op code 2 accepts size codes 1 to 3 only. Size code 0 and codes above 3 set the error flag.
- R6: Op codes 3 and 5 widen A elements 0 to N/2-1 into double-width destination elements 0 to N/2-1. Op codes 4 and 6 widen A elements N/2 to N-1 into the same destination elements. N is the source element count.
- R7: Op codes 3 and 4 sign-extend the widened elements. Op codes 5 and 6 zero-extend them.
- R8: Op codes 3 to 6 accept size codes 0 to 2 only. Any other size code sets the error flag.
- R9: Op code 7 writes two 64-bit results. Bits [127:64] hold A element N/2-1 sign-extended, and bits [63:0] hold A element N-1 sign-extended. This gives indices 7 and 15 for bytes, 3 and 7 for halfwords, and 1 and 3 for words. Size codes 3 to 7 set the error flag.
- R10: Whenever the error flag is set, the result is all zeros.
- R11: out_valid rises exactly one cycle after each in_valid cycle. It is low in every cycle that follows a cycle without in_valid.
- R12: In a cycle without in_valid, result_o and err_o keep their previous values.
- R13: A synchronous active-high reset clears out_valid, result_o and err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_i | input | 3 | Operation code (0..7, see requirements) |
| size_i | input | 3 | Element size code (0=8, 1=16, 2=32, 3=64 bits) |
| a_i | input | 128 | Source vector A |
| b_i | input | 128 | Source vector B |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result_o | output | 128 | Registered result vector |
| err_o | output | 1 | Unsupported size for the operation |

## Verification
The unit's only internal state is the output register. A fault in an index formula, an extension choice or a size decode therefore shows up as a wrong result_o or err_o in the very next cycle after the offending request. A fault in the hold or valid logic shows up in the first idle cycle after a request, as a changed result or a spurious out_valid. Comparing the outputs against a behavioural model on every clock, across every operation and size code with varied operand patterns, exposes each of these faults within one cycle of the stimulus that triggers it.

// File: rtl/vsu_pkg.sv
package vsu_pkg;
  typedef enum logic [2:0] {
    VSU_MRG_HI  = 3'd0,
    VSU_MRG_LO  = 3'd1,
    VSU_NARROW  = 3'd2,
    VSU_WID_HS  = 3'd3,
    VSU_WID_LS  = 3'd4,
    VSU_WID_HZ  = 3'd5,
    VSU_WID_LZ  = 3'd6,
    VSU_SEXT_DW = 3'd7
  } vsu_op_e;
  localparam int VSU_OP_W = 3;
  localparam int VSU_SZ_W = 3;
endpackage

// File: rtl/vsu_merge.sv
module vsu_merge #(
  parameter int VW  = 128,
  parameter int NSZ = 4
) (
  input  logic [VW-1:0]           a_i,
  input  logic [VW-1:0]           b_i,
  input  logic                    lo_i,
  input  logic [$clog2(NSZ)-1:0]  sz_i,
  output logic [VW-1:0]           res_o
);
  logic [VW-1:0] hi_v [NSZ];
  logic [VW-1:0] lo_v [NSZ];

  for (genvar s = 0; s < NSZ; s++) begin : g_sz
    localparam int EW = 8 << s;
    localparam int N  = VW / EW;
    logic [VW-1:0] hv, lv;
    for (genvar d = 0; d < N; d++) begin : g_el
      localparam int SH = d / 2;
      localparam int SL = (d + N) / 2;
      if (d % 2 == 0) begin : g_even
        assign hv[VW-1-d*EW -: EW] = a_i[VW-1-SH*EW -: EW];
        assign lv[VW-1-d*EW -: EW] = a_i[VW-1-SL*EW -: EW];
      end else begin : g_odd
        assign hv[VW-1-d*EW -: EW] = b_i[VW-1-SH*EW -: EW];
        assign lv[VW-1-d*EW -: EW] = b_i[VW-1-SL*EW -: EW];
      end
    end
    assign hi_v[s] = hv;
    assign lo_v[s] = lv;
  end

  always_comb res_o = lo_i ? lo_v[sz_i] : hi_v[sz_i];
endmodule

// File: rtl/vsu_narrow.sv
module vsu_narrow #(
  parameter int VW  = 128,
  parameter int NSZ = 4
) (
  input  logic [VW-1:0]           a_i,
  input  logic [VW-1:0]           b_i,
  input  logic [$clog2(NSZ)-1:0]  sz_i,
  output logic [VW-1:0]           res_o
);
  logic [VW-1:0] nv [NSZ];

  assign nv[0] = '0;
  for (genvar s = 1; s < NSZ; s++) begin : g_sz
    localparam int SW = 8 << s;
    localparam int DW = SW / 2;
    localparam int NS = VW / SW;
    logic [VW-1:0] pv;
    for (genvar d = 0; d < NS; d++) begin : g_el
      assign pv[VW-1-d*DW -: DW]      = a_i[VW-1-d*SW-DW -: DW];
      assign pv[VW-1-(d+NS)*DW -: DW] = b_i[VW-1-d*SW-DW -: DW];
    end
    assign nv[s] = pv;
  end

  always_comb res_o = nv[sz_i];
endmodule

// File: rtl/vsu_widen.sv
module vsu_widen #(
  parameter int VW  = 128,
  parameter int NSZ = 4
) (
  input  logic [VW-1:0]           a_i,
  input  logic                    lo_i,
  input  logic                    sgn_i,
  input  logic                    dw_i,
  input  logic [$clog2(NSZ)-1:0]  sz_i,
  output logic [VW-1:0]           res_o
);
  localparam int QW = 8 << (NSZ - 1);
  logic [VW-1:0] wv [NSZ];
  logic [VW-1:0] sv [NSZ];

  assign wv[NSZ-1] = '0;
  assign sv[NSZ-1] = '0;
  for (genvar s = 0; s < NSZ - 1; s++) begin : g_sz
    localparam int SW = 8 << s;
    localparam int DW = 2 * SW;
    localparam int NS = VW / SW;
    localparam int ND = NS / 2;
    logic [VW-1:0] ww;
    logic [SW-1:0] e_up, e_dn;
    for (genvar d = 0; d < ND; d++) begin : g_el
      logic [SW-1:0] pick;
      assign pick = lo_i ? a_i[VW-1-(d+ND)*SW -: SW] : a_i[VW-1-d*SW -: SW];
      assign ww[VW-1-d*DW -: DW] = {{SW{sgn_i & pick[SW-1]}}, pick};
    end
    assign e_up  = a_i[VW-1-(ND-1)*SW -: SW];
    assign e_dn  = a_i[VW-1-(NS-1)*SW -: SW];
    assign wv[s] = ww;
    assign sv[s] = {{(QW-SW){e_up[SW-1]}}, e_up, {(QW-SW){e_dn[SW-1]}}, e_dn};
  end

  always_comb res_o = dw_i ? sv[sz_i] : wv[sz_i];
endmodule

// File: rtl/vec_shuffle_unit.sv
module vec_shuffle_unit
  import vsu_pkg::*;
#(
  parameter int VW  = 128,
  parameter int NSZ = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [VSU_OP_W-1:0] op_i,
  input  logic [VSU_SZ_W-1:0] size_i,
  input  logic [VW-1:0]       a_i,
  input  logic [VW-1:0]       b_i,
  output logic                out_valid,
  output logic [VW-1:0]       result_o,
  output logic                err_o
);
  localparam int IW = $clog2(NSZ);
  localparam logic [VSU_SZ_W-1:0] SZ_TOP  = VSU_SZ_W'(NSZ - 1);
  localparam logic [VSU_SZ_W-1:0] SZ_WTOP = VSU_SZ_W'(NSZ - 2);

  vsu_op_e       op;
  logic [IW-1:0] sz;
  logic [VW-1:0] mrg_v, nar_v, wid_v, nxt;
  logic          bad, wlo, wsgn, wdw;

  assign op = vsu_op_e'(op_i);
  assign sz = size_i[IW-1:0];

  assign wlo  = (op == VSU_WID_LS) || (op == VSU_WID_LZ);
  assign wsgn = (op == VSU_WID_HS) || (op == VSU_WID_LS);
  assign wdw  = (op == VSU_SEXT_DW);

  vsu_merge #(.VW(VW), .NSZ(NSZ)) u_merge (
    .a_i(a_i), .b_i(b_i), .lo_i(op == VSU_MRG_LO), .sz_i(sz), .res_o(mrg_v));

  vsu_narrow #(.VW(VW), .NSZ(NSZ)) u_narrow (
    .a_i(a_i), .b_i(b_i), .sz_i(sz), .res_o(nar_v));

  vsu_widen #(.VW(VW), .NSZ(NSZ)) u_widen (
    .a_i(a_i), .lo_i(wlo), .sgn_i(wsgn), .dw_i(wdw), .sz_i(sz), .res_o(wid_v));

  always_comb begin
    unique case (op)
      VSU_MRG_HI, VSU_MRG_LO: begin
        bad = size_i > SZ_TOP;
        nxt = mrg_v;
      end
      VSU_NARROW: begin
        bad = (size_i == '0) || (size_i > SZ_TOP);
        nxt = nar_v;
      end
      default: begin
        bad = size_i > SZ_WTOP;
        nxt = wid_v;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result_o  <= '0;
      err_o     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        err_o    <= bad;
        result_o <= bad ? '0 : nxt;
      end
    end
  end
endmodule

// File: rtl/vsu_checks.sv
module vsu_checks #(
  parameter int VW = 128
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    op_i,
  input logic [2:0]    size_i,
  input logic          out_valid,
  input logic [VW-1:0] result_o,
  input logic          err_o
);
  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drops_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result_o) && $stable(err_o)));
  assert_err_zero_R10: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (result_o == '0));
  assert_merge_ok_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_i <= 3'd1 && size_i <= 3'd3) |=> !err_o);
  assert_narrow_bad_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_i == 3'd2 && size_i == 3'd0) |=> err_o);
  assert_widen_bad_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_i >= 3'd3 && op_i <= 3'd6 && size_i == 3'd3) |=> err_o);
  assert_sext_bad_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_i == 3'd7 && size_i >= 3'd3) |=> err_o);
endmodule

bind vec_shuffle_unit vsu_checks #(.VW(VW)) u_vsu_checks (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_i(op_i), .size_i(size_i),
  .out_valid(out_valid), .result_o(result_o), .err_o(err_o));

// File: tb/test_vec_shuffle_unit.sv
module test_vec_shuffle_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [2:0]   op_i = '0;
  logic [2:0]   size_i = '0;
  logic [127:0] a_i = '0;
  logic [127:0] b_i = '0;
  logic         out_valid;
  logic [127:0] result_o;
  logic         err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_shuffle_unit i_vec_shuffle_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_i(op_i), .size_i(size_i),
    .a_i(a_i), .b_i(b_i), .out_valid(out_valid), .result_o(result_o), .err_o(err_o));

  function automatic logic [127:0] getel(logic [127:0] v, int w, int i);
    logic [127:0] m = (128'd1 << w) - 128'd1;
    return (v >> (128 - (i + 1) * w)) & m;
  endfunction

  function automatic logic [127:0] putel(logic [127:0] r, int w, int i, logic [127:0] e);
    logic [127:0] m = (128'd1 << w) - 128'd1;
    return r | ((e & m) << (128 - (i + 1) * w));
  endfunction

  function automatic logic [127:0] extend(logic [127:0] e, int w, bit sgn);
    logic [127:0] m = (128'd1 << w) - 128'd1;
    if (sgn && e[w-1]) return e | ~m;
    return e;
  endfunction

  // returns {error, result}
  function automatic logic [128:0] ref_calc(int op, int sz, logic [127:0] a, logic [127:0] b);
    logic [127:0] r = '0;
    int w = 8 << sz;
    int n;
    case (op)
      0, 1: begin
        if (sz > 3) return {1'b1, 128'd0};
        n = 128 / w;
        for (int d = 0; d < n; d++) begin
          int si = (op == 0) ? d / 2 : (d + n) / 2;
          r = putel(r, w, d, getel((d % 2) ? b : a, w, si));
        end
      end
      2: begin
        if (sz == 0 || sz > 3) return {1'b1, 128'd0};
        n = 128 / w;
        for (int d = 0; d < 2 * n; d++)
          r = putel(r, w / 2, d, (d < n) ? getel(a, w, d) : getel(b, w, d - n));
      end
      3, 4, 5, 6: begin
        if (sz > 2) return {1'b1, 128'd0};
        n = 128 / w;
        for (int d = 0; d < n / 2; d++) begin
          int si = (op == 3 || op == 5) ? d : d + n / 2;
          r = putel(r, 2 * w, d, extend(getel(a, w, si), w, op == 3 || op == 4));
        end
      end
      default: begin
        if (sz > 2) return {1'b1, 128'd0};
        n = 128 / w;
        r = putel(r, 64, 0, extend(getel(a, w, n / 2 - 1), w, 1'b1));
        r = putel(r, 64, 1, extend(getel(a, w, n - 1), w, 1'b1));
      end
    endcase
    return {1'b0, r};
  endfunction

  function automatic string tag_of(int op, int sz);
    case (op)
      0: return (sz > 3) ? "R3" : "R1";
      1: return (sz > 3) ? "R3" : "R2";
      2: return (sz == 0 || sz > 3) ? "R5" : "R4";
      3, 4: return (sz > 2) ? "R8" : "R6";
      5, 6: return (sz > 2) ? "R8" : "R7";
      default: return "R9";
    endcase
  endfunction

  // behavioural model state
  bit           m_valid = 0;
  logic [127:0] m_res = '0;
  bit           m_err = 0;
  string        m_tag = "R13";

  always @(posedge clk) begin
    logic [128:0] x;
    if (rst) begin
      m_valid = 0; m_res = '0; m_err = 0; m_tag = "R13";
    end else begin
      m_valid = in_valid;
      if (in_valid) begin
        x = ref_calc(int'(op_i), int'(size_i), a_i, b_i);
        m_err = x[128]; m_res = x[127:0];
        m_tag = tag_of(int'(op_i), int'(size_i));
      end else begin
        m_tag = "R12";
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (out_valid !== m_valid) begin
        errors++;
        $display("FAIL R11 out_valid actual %0b expected %0b", out_valid, m_valid);
      end
      checks++;
      if (result_o !== m_res || err_o !== m_err) begin
        errors++;
        $display("FAIL %s result %h err %0b expected %h err %0b",
                 m_tag, result_o, err_o, m_res, m_err);
      end
      if (err_o === 1'b1) begin
        checks++;
        if (result_o !== '0) begin
          errors++;
          $display("FAIL R10 result %h expected 0", result_o);
        end
      end
    end
  end

  task automatic issue(int op, int sz, logic [127:0] a, logic [127:0] b);
    @(negedge clk);
    in_valid = 1'b1; op_i = 3'(op); size_i = 3'(sz); a_i = a; b_i = b;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      a_i = {4{$urandom}}; b_i = {4{$urandom}}; op_i = 3'($urandom); size_i = 3'($urandom);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] seq_a, seq_b;
    for (int i = 0; i < 16; i++) begin
      seq_a[127 - 8*i -: 8] = 8'(i);
      seq_b[127 - 8*i -: 8] = 8'(16 + i);
    end
    repeat (3) @(negedge clk);
    // R13: reset state
    checks++;
    if (out_valid !== 1'b0 || result_o !== '0 || err_o !== 1'b0) begin
      errors++;
      $display("FAIL R13 reset state %0b %h %0b expected 0 0 0", out_valid, result_o, err_o);
    end
    rst = 1'b0;
    // R1/R2 with ordered byte patterns, every size
    for (int s = 0; s < 4; s++) begin
      issue(0, s, seq_a, seq_b);
      issue(1, s, seq_a, seq_b);
    end
    idle(2);
    // R4, R5: narrow on all sizes incl. illegal
    for (int s = 0; s < 8; s++) begin issue(2, s, seq_a, seq_b); idle(1); end
    // R6, R7: widen with negative-signed and positive elements
    for (int s = 0; s < 4; s++)
      for (int op = 3; op <= 6; op++) issue(op, s, {8{16'h80_7f}}, seq_b);
    // R9: sign-extend to doubleword, both signs
    for (int s = 0; s < 8; s++) begin
      issue(7, s, {16{8'hf0}}, '0);
      issue(7, s, seq_a, '0);
    end
    idle(3);
    // sweep every op and size with random operands, mixing gaps (R12)
    for (int rep = 0; rep < 40; rep++)
      for (int op = 0; op < 8; op++)
        for (int s = 0; s < 8; s++) begin
          issue(op, s, rnd128(), rnd128());
          if ($urandom_range(3) == 0) idle(1 + $urandom_range(2));
        end
    idle(3);
    // R13: synchronous reset mid-stream
    issue(0, 0, seq_a, seq_b);
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule